// File: doc/BRIEF.md
# Retriggerable Page Load Controller

This block manages the page-mode write path of a word-wide non-volatile memory model. Word writes arrive on a chip-select / write-enable / output-enable strobe set, sampled on the system clock. Each completed write is parked in a page buffer slot chosen by the low address bits. A retriggerable one-shot measures the quiet gap after the last write strobe. When that window lapses, the block enters a programming phase of fixed length. During that phase it replays every buffered word to the storage array as a stream of array write commands and holds a busy flag high.

While programming runs, the polled read value of the most recently written word is returned with its bit 7 and bit 15 inverted. This gives software a cheap way to detect the end of programming: it reads that word until the data comes back true. An allow-store input decides whether the replay actually writes the array. When it is low, the full programming time still elapses, but nothing is written.

Top module: `page_load_ctrl`

## Requirements
- R1: A write cycle begins on the first clock at which cs_n and we_n are both low while oe_n is high, and the address is captured then. It completes on the first clock at which either strobe is high again, and the data is captured then. The word goes into the page buffer slot addr[6:0], whichever strobe (we_n or cs_n) shapes the cycle.
- R2: A strobe pair applied while oe_n is low neither stores a word nor opens a load window.
- R3: Each write-cycle start, and each high-to-low step of we_n while oe_n is high, restarts the load window while loading. busy rises on exactly the WIN_CYC-th clock edge after the last restart.
- R4: The programming phase keeps busy high for exactly PROG_CYC cycles, whether one word or many were loaded.
- R5: During programming, arr_we pulses once for each slot written in the burst, in ascending slot order. The pulse carries arr_addr = {page, slot} and the last data written to that slot. Slots not written in the burst produce no command.
- R6: The page (addr[16:7]) is fixed by the first accepted write of a burst. A later write to another page pulses page_err for one cycle and is neither stored nor reflected on the poll outputs.
- R7: Write strobes applied while busy is high are ignored. They store nothing, change no poll output and start no new load window.
- R8: poll_addr and poll_data show the last accepted write. While busy is high, poll_data has bits 7 and 15 inverted. Otherwise every bit is true.
- R9: With store_ok low during programming, no arr_we pulse is produced, but busy still lasts PROG_CYC cycles.
- R10: After reset, busy, arr_we and page_err are low, and poll_data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low; low blocks writes |
| addr | input | ADDR_W | Word address; low 7 bits select the slot |
| wdata | input | DATA_W | Write data |
| store_ok | input | 1 | Allows array writes during programming |
| arr_we | output | 1 | Array write command strobe |
| arr_addr | output | ADDR_W | Array write address |
| arr_data | output | DATA_W | Array write data |
| busy | output | 1 | Programming phase in progress |
| page_err | output | 1 | One-cycle pulse on a rejected cross-page write |
| poll_addr | output | ADDR_W | Address of the last accepted write |
| poll_data | output | DATA_W | Polled data of the last accepted write |

## Verification
The load path is driven with write-enable-shaped cycles, chip-select-shaped cycles, a repeated write to one slot and a bare we_n pulse with chip select high. Together these show that the correct strobe edges capture address and data, that overwrites keep only the last value, and that a lone we_n fall still retriggers the window. The exact busy edge after a burst pins the window length. Busy is timed for a one-word and a multi-word burst to show the programming time does not depend on the load. Output-enable-low, cross-page and during-programming writes each show that an ignored write leaves nothing in the commit stream or poll outputs. A programming phase with store_ok low separates the timing of programming from the array write itself.

// File: rtl/pload_pkg.sv
package pload_pkg;

  typedef enum logic [1:0] {
    PL_IDLE = 2'd0,
    PL_LOAD = 2'd1,
    PL_PROG = 2'd2
  } pl_state_e;

  // Polling inversion: top bit of each byte lane pair (7 and 15 for 16 bits).
  function automatic logic [63:0] poll_flip(input int unsigned w);
    logic [63:0] m;
    m = '0;
    m[w - 1] = 1'b1;
    m[(w / 2) - 1] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/pload_strobe.sv
module pload_strobe #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              allow,
  output logic              wr_start,
  output logic              wr_done,
  output logic              we_fall,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [DATA_W-1:0] cap_data
);

  logic act, act_q, we_q, live;
  logic start_raw, end_raw;
  logic [ADDR_W-1:0] addr_q;

  // A cycle exists only while both strobes are low and outputs are disabled.
  assign act       = ~cs_n & ~we_n & oe_n;
  assign start_raw = act & ~act_q;
  assign end_raw   = ~act & act_q;

  assign wr_start = start_raw & allow;
  assign wr_done  = end_raw & live & allow;
  assign we_fall  = we_q & ~we_n & oe_n & allow;
  assign cap_addr = addr_q;
  assign cap_data = wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      we_q   <= 1'b1;
      live   <= 1'b0;
      addr_q <= '0;
    end else begin
      act_q <= act;
      we_q  <= we_n;
      if (!allow) begin
        live <= 1'b0;
      end else if (start_raw) begin
        live   <= 1'b1;
        addr_q <= addr;
      end else if (end_raw) begin
        live <= 1'b0;
      end
    end
  end

  // R1: an accepted start leaves a cycle open with the sampled address.
  p_start_opens_r1: assert property (@(posedge clk) disable iff (rst)
    wr_start |=> (live && cap_addr == $past(addr)));

  // R2: with outputs enabled no cycle can open.
  p_oe_blocks_r2: assert property (@(posedge clk) disable iff (rst)
    (!oe_n && !live) |=> !live);

endmodule

// File: rtl/pload_timer.sv
module pload_timer #(
  parameter int WIN_CYC = 18750
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  output logic expire
);

  localparam int TW = $clog2(WIN_CYC + 1);

  logic [TW-1:0] cnt;

  assign expire = run & ~restart & (cnt == TW'(WIN_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst || !run || restart) begin
      cnt <= '0;
    end else if (!expire) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R3: a retrigger always brings the window back to its start.
  p_restart_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (run && restart) |=> (cnt == '0));

  // R3: the count never passes the window length.
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    cnt <= TW'(WIN_CYC - 1));

endmodule

// File: rtl/pload_buf.sv
module pload_buf #(
  parameter int WORDS  = 128,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clear,
  input  logic                     wr_en,
  input  logic [$clog2(WORDS)-1:0] wr_idx,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [$clog2(WORDS)-1:0] rd_idx,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     rd_vld
);

  logic [DATA_W-1:0] mem [WORDS];
  logic [WORDS-1:0]  valid;

  // Plain synchronous-read array so it maps onto block RAM.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
    rd_data <= mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      valid <= '0;
    end else if (wr_en) begin
      valid[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_vld <= 1'b0;
    else     rd_vld <= valid[rd_idx];
  end

  // R5: a finished page leaves no slot marked for the next burst.
  p_clear_empty_r5: assert property (@(posedge clk) disable iff (rst)
    clear |=> (valid == '0));

endmodule

// File: rtl/page_load_ctrl.sv
module page_load_ctrl
  import pload_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 16,
  parameter int WORDS    = 128,
  parameter int WIN_CYC  = 18750,
  parameter int PROG_CYC = 1250000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              store_ok,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_data,
  output logic              busy,
  output logic              page_err,
  output logic [ADDR_W-1:0] poll_addr,
  output logic [DATA_W-1:0] poll_data
);

  localparam int IW       = $clog2(WORDS);
  localparam int PW       = ADDR_W - IW;
  localparam int PROG_LEN = (PROG_CYC < WORDS + 2) ? WORDS + 2 : PROG_CYC;
  localparam int PCW      = $clog2(PROG_LEN + 1);
  localparam logic [63:0] FLIP64 = poll_flip(DATA_W);
  localparam logic [DATA_W-1:0] FLIP = FLIP64[DATA_W-1:0];

  pl_state_e state;
  logic [PCW-1:0] pcnt;

  logic              allow;
  logic              wr_start, wr_done, we_fall;
  logic [ADDR_W-1:0] cap_addr;
  logic [DATA_W-1:0] cap_data;
  logic [IW-1:0]     cap_idx;
  logic [PW-1:0]     cap_page;

  logic          has_page;
  logic [PW-1:0] page_q;
  logic          take, reject;

  logic              expire, prog_end, rd_go;
  logic [IW-1:0]     rd_idx;
  logic              p1_go;
  logic [IW-1:0]     p1_idx;
  logic [DATA_W-1:0] rd_data;
  logic              rd_vld;

  logic [ADDR_W-1:0] last_addr;
  logic [DATA_W-1:0] last_data;

  assign allow    = (state != PL_PROG);
  assign cap_idx  = cap_addr[IW-1:0];
  assign cap_page = cap_addr[ADDR_W-1:IW];

  pload_strobe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_strobe (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (cs_n),
    .we_n     (we_n),
    .oe_n     (oe_n),
    .addr     (addr),
    .wdata    (wdata),
    .allow    (allow),
    .wr_start (wr_start),
    .wr_done  (wr_done),
    .we_fall  (we_fall),
    .cap_addr (cap_addr),
    .cap_data (cap_data)
  );

  assign take   = wr_done & (~has_page | (cap_page == page_q));
  assign reject = wr_done & has_page & (cap_page != page_q);

  pload_timer #(.WIN_CYC(WIN_CYC)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .run     (state == PL_LOAD),
    .restart (wr_start | we_fall),
    .expire  (expire)
  );

  assign prog_end = (state == PL_PROG) && (pcnt == PCW'(PROG_LEN - 1));
  assign rd_go    = (state == PL_PROG) && (pcnt < PCW'(WORDS));
  assign rd_idx   = pcnt[IW-1:0];

  pload_buf #(.WORDS(WORDS), .DATA_W(DATA_W)) u_buf (
    .clk     (clk),
    .rst     (rst),
    .clear   (prog_end),
    .wr_en   (take),
    .wr_idx  (cap_idx),
    .wr_data (cap_data),
    .rd_idx  (rd_idx),
    .rd_data (rd_data),
    .rd_vld  (rd_vld)
  );

  // Phase control: idle, burst loading, fixed-length programming.
  always_ff @(posedge clk) begin
    if (rst) begin
      state <= PL_IDLE;
      pcnt  <= '0;
    end else begin
      case (state)
        PL_IDLE: if (wr_start) state <= PL_LOAD;
        PL_LOAD: if (expire) begin
          state <= PL_PROG;
          pcnt  <= '0;
        end
        PL_PROG: if (prog_end) state <= PL_IDLE;
                 else          pcnt  <= pcnt + 1'b1;
        default: state <= PL_IDLE;
      endcase
    end
  end

  // Page ownership of the current burst.
  always_ff @(posedge clk) begin
    if (rst) begin
      has_page <= 1'b0;
      page_q   <= '0;
      page_err <= 1'b0;
    end else begin
      page_err <= reject;
      if (prog_end) begin
        has_page <= 1'b0;
      end else if (take && !has_page) begin
        has_page <= 1'b1;
        page_q   <= cap_page;
      end
    end
  end

  // Last accepted word, for polling.
  always_ff @(posedge clk) begin
    if (rst) begin
      last_addr <= '0;
      last_data <= '0;
    end else if (take) begin
      last_addr <= cap_addr;
      last_data <= cap_data;
    end
  end

  // Replay pipeline: slot read, then registered array command.
  always_ff @(posedge clk) begin
    if (rst) begin
      p1_go    <= 1'b0;
      p1_idx   <= '0;
      arr_we   <= 1'b0;
      arr_addr <= '0;
      arr_data <= '0;
    end else begin
      p1_go    <= rd_go;
      p1_idx   <= rd_idx;
      arr_we   <= p1_go & rd_vld & store_ok;
      arr_addr <= {page_q, p1_idx};
      arr_data <= rd_data;
    end
  end

  assign busy      = (state == PL_PROG);
  assign poll_addr = last_addr;
  assign poll_data = busy ? (last_data ^ FLIP) : last_data;

  // R3: a lapsed window always starts programming on the next edge.
  p_expire_busy_r3: assert property (@(posedge clk) disable iff (rst)
    ((state == PL_LOAD) && expire) |=> busy);

  // R5: array commands only appear inside the programming phase.
  p_cmd_in_prog_r5: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> busy);

  // R9: no array command without permission one cycle earlier.
  p_store_gate_r9: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> $past(store_ok));

  // R6: a rejected write never moves the polled address.
  p_reject_keeps_poll_r6: assert property (@(posedge clk) disable iff (rst)
    page_err |-> $stable(poll_addr));

  // R7: poll state is frozen across programming.
  p_prog_frozen_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(poll_addr) && !page_err));

endmodule

// File: tb/page_load_ctrl_test.sv
module page_load_ctrl_test;

  localparam int AW = 17;
  localparam int DW = 16;
  localparam int NW = 128;
  localparam int WIN = 40;
  localparam int PROG = 200;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, store_ok = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic arr_we, busy, page_err;
  logic [AW-1:0] arr_addr, poll_addr;
  logic [DW-1:0] arr_data, poll_data;

  int checks = 0;
  int fails = 0;
  int arr_seen = 0;

  logic [AW+DW-1:0] exp_q[$];
  bit               m_valid[NW];
  logic [DW-1:0]    m_data[NW];
  bit               m_has = 0;
  logic [9:0]       m_page = '0;

  always #4 clk = ~clk;

  page_load_ctrl #(.ADDR_W(AW), .DATA_W(DW), .WORDS(NW),
                   .WIN_CYC(WIN), .PROG_CYC(PROG)) uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .wdata(wdata), .store_ok(store_ok),
    .arr_we(arr_we), .arr_addr(arr_addr), .arr_data(arr_data),
    .busy(busy), .page_err(page_err),
    .poll_addr(poll_addr), .poll_data(poll_data)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] flip(input logic [DW-1:0] d);
    return d ^ 16'h8080;
  endfunction

  // Monitor: pop and compare each array command (R5).
  always @(negedge clk) begin
    if (!rst && arr_we) begin
      arr_seen++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5 unexpected command", {arr_addr, arr_data}, 0);
      end else begin
        logic [AW+DW-1:0] e;
        e = exp_q.pop_front();
        chk({arr_addr, arr_data} == e, "R5 commit", {arr_addr, arr_data}, e);
      end
    end
  end

  // Driver side of the scoreboard: queue the expected page commit.
  task automatic push_commit(input bit store);
    for (int i = 0; i < NW; i++) begin
      if (m_valid[i] && store) exp_q.push_back({m_page, 7'(i), m_data[i]});
      m_valid[i] = 1'b0;
    end
    m_has = 1'b0;
  endtask

  function automatic void model_take(input logic [AW-1:0] a, input logic [DW-1:0] d);
    if (!m_has) begin
      m_has = 1'b1;
      m_page = a[16:7];
    end
    m_valid[a[6:0]] = 1'b1;
    m_data[a[6:0]] = d;
  endfunction

  // Write-enable shaped write cycle; ends on the negedge after completion.
  task automatic we_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input bit oe_low, input bit take, input bit err,
                          input string req);
    logic [AW-1:0] pa;
    pa = poll_addr;
    @(negedge clk);
    addr = a; wdata = d; oe_n = ~oe_low; cs_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    cs_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
    oe_n = 1'b1;
    chk(page_err == err, {req, " page_err"}, page_err, err);
    if (take) begin
      model_take(a, d);
      chk(poll_addr == a, {req, " poll_addr"}, poll_addr, a);
    end else begin
      chk(poll_addr == pa, {req, " poll_addr kept"}, poll_addr, pa);
    end
  endtask

  // Chip-select shaped write cycle: we_n leads, cs_n rises first.
  task automatic cs_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    addr = a; wdata = d; we_n = 1'b0;
    @(negedge clk);
    cs_n = 1'b0;
    @(negedge clk);
    cs_n = 1'b1;
    @(negedge clk);
    we_n = 1'b1;
    model_take(a, d);
    chk(poll_addr == a && poll_data == d, "R1 cs-shaped capture",
        {poll_addr, poll_data}, {a, d});
  endtask

  task automatic wait_busy_rise(input bit store);
    for (int i = 0; i < WIN + 20 && !busy; i++) @(negedge clk);
    chk(busy, "R3 busy rise", busy, 1);
    push_commit(store);
  endtask

  task automatic measure_busy(input bit store, output int n);
    wait_busy_rise(store);
    n = 0;
    while (busy && n < PROG + 20) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    int n1;
    int nk;
    int seen0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(!busy && !arr_we && !page_err && poll_data == 0, "R10 reset",
        {busy, arr_we, page_err, poll_data}, 0);

    // R2: write with outputs enabled is blocked
    we_write({10'h050, 7'd5}, 16'hDEAD, 1'b1, 1'b0, 1'b0, "R2");
    repeat (WIN + 10) @(negedge clk);
    chk(!busy && poll_data == 0, "R2 no burst", {busy, poll_data}, 0);

    // Burst A: overwrite of slot 3, exact window timing
    we_write({10'h015, 7'd3}, 16'h1234, 1'b0, 1'b1, 1'b0, "R1");
    we_write({10'h015, 7'd0}, 16'hABCD, 1'b0, 1'b1, 1'b0, "R1");
    we_write({10'h015, 7'd3}, 16'h5678, 1'b0, 1'b1, 1'b0, "R1");
    chk(poll_data == 16'h5678, "R8 true while loading", poll_data, 16'h5678);
    repeat (WIN - 2) @(negedge clk);
    chk(!busy, "R3 window not yet lapsed", busy, 0);
    @(negedge clk);
    chk(busy, "R3 busy on window edge", busy, 1);
    push_commit(1'b1);
    chk(poll_data == flip(16'h5678), "R8 inverted while busy",
        poll_data, flip(16'h5678));
    // R7: write during programming is ignored
    we_write({10'h015, 7'd9}, 16'h1111, 1'b0, 1'b0, 1'b0, "R7");
    chk(poll_data == flip(16'h5678), "R7 poll unchanged",
        poll_data, flip(16'h5678));
    for (int i = 0; i < PROG + 10 && busy; i++) @(negedge clk);
    chk(poll_data == 16'h5678, "R8 true after programming", poll_data, 16'h5678);
    repeat (WIN + 10) @(negedge clk);
    chk(!busy, "R7 no burst from ignored write", busy, 0);

    // Burst B: we_n retrigger, cross-page reject, cs-shaped write
    we_write({10'h002, 7'd5}, 16'h0F0F, 1'b0, 1'b1, 1'b0, "R1");
    repeat (30) @(negedge clk);
    we_n = 1'b0;
    @(negedge clk);
    we_n = 1'b1;
    repeat (33) @(negedge clk);
    chk(!busy, "R3 we_n fall retriggered", busy, 0);
    we_write({10'h003, 7'd6}, 16'h7777, 1'b0, 1'b0, 1'b1, "R6");
    chk(poll_data == 16'h0F0F, "R6 poll data kept", poll_data, 16'h0F0F);
    cs_write({10'h002, 7'd127}, 16'h8001);
    measure_busy(1'b1, nk);
    chk(nk == PROG, "R4 length with several words", nk, PROG);

    // Burst C: one word, store disabled
    store_ok = 1'b0;
    seen0 = arr_seen;
    we_write({10'h007, 7'd64}, 16'h2222, 1'b0, 1'b1, 1'b0, "R9");
    measure_busy(1'b0, n1);
    chk(n1 == PROG, "R4 length with one word", n1, PROG);
    chk(arr_seen == seen0, "R9 no array command", arr_seen, seen0);
    store_ok = 1'b1;
    repeat (5) @(negedge clk);

    chk(exp_q.size() == 0, "R5 all commits seen", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule